// File: doc/BRIEF.md
# Link Powerdown and Warm-Wake Controller

This block sits beside the register file of an audio codec and owns its staged shutdown. Software turns off the converter sections one at a time by writing a five-bit powerdown word. Each of the four low bits drives an active-high disable for one section, and every disable takes effect on the cycle after the write. The top bit asks for the serial link itself to stop. That request is honoured only when all four sections are already off in the same word. It takes effect at the end of the frame that carried the write, and from then on the bit clock is held low.

The bit clock comes from the always-running crystal clock through an even divider (by two by default). While the link sleeps, every powerdown bit keeps its value. A high pulse on the frame-sync input then acts as a warm wake, provided it lasts at least `MIN_SYNC_CYC` crystal cycles (25 by default). The wake is recognised when the pulse falls. It clears the link-off bit and restarts the bit clock, while the section disables stay as they were. Shorter pulses are ignored, and so is sync activity while the link is running. Pulling the active-low cold reset low clears everything at any time, including during sleep.

Top module: `link_pwr_ctrl`

## Requirements
- R1: After cold reset `sect_off` is 0, `link_off` is 0, `pd_rdata` is 0, `ready` is all ones, and `bitclk` toggles, giving 10 rising edges in any 20 crystal cycles.
- R2: While the link runs, a write (`pd_wr`=1) copies `pd_wdata[3:0]` into `sect_off` from the next cycle. The bits are 0=ADC, 1=DAC, 2=mixer, 3=reference. `ready[i]` is the inverse of `sect_off[i]`, and `ready[4]` is the inverse of `link_off`.
- R3: A write with `pd_wdata[4]`=1 but `pd_wdata[3:0]` not equal to 4'hF does not set the link-off request: `pd_rdata[4]` stays 0 and the link never halts.
- R4: An accepted link-off write shows at once as `pd_rdata[4]`=1, while the bit clock keeps running. `link_off` rises in the cycle after the next `frame_done` pulse.
- R5: While `link_off` is 1, `bitclk` stays low.
- R6: While the link is halted, writes and `frame_done` have no effect: `pd_rdata`, `sect_off` and `link_off` hold their values.
- R7: A sync pulse that is high for at least 25 crystal cycles while halted clears `link_off` and `pd_rdata[4]` within 8 cycles of its fall. The section disables are kept, and `bitclk` toggles again.
- R8: A sync pulse shorter than 25 crystal cycles while halted is ignored and the link stays halted.
- R9: Sync pulses of any width while the link runs have no effect.
- R10: Cold reset during sleep restores the reset state of R1.
- R11: A write that clears `pd_wdata[4]` before the frame ends cancels a pending link-off request, so the link does not halt at that frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Free-running crystal clock |
| resetb | input | 1 | Active-low cold reset, asynchronous assert |
| sync_in | input | 1 | Frame-sync line, watched for warm wake while halted |
| pd_wr | input | 1 | Powerdown register write strobe |
| pd_wdata | input | 5 | Powerdown write word: [3:0] section disables, [4] link-off request |
| frame_done | input | 1 | One-cycle pulse on the last crystal cycle of a link frame |
| bitclk | output | 1 | Divided serial bit clock, held low while halted |
| sect_off | output | 4 | Active-high section disables (ADC, DAC, mixer, reference) |
| link_off | output | 1 | High while the serial link is halted |
| pd_rdata | output | 5 | Powerdown register readback ([4] = request pending or halted) |
| ready | output | 5 | Per-section ready status, [4] for the link |

## Verification
The bench aims at the exact wake threshold. It sends pulses of 24 and 25 cycles, so a counter that is off by one would either wake on the short pulse or miss the valid one. It sends a link-off request that lacks one section bit, which a design that did not gate on all four bits would obey by halting early. It also checks that the halt waits for the frame end, and that a cancelling write before that point leaves the link running; a design that halted at once or latched the request would fail both. Writes, frame pulses and sync pulses sent while the link is in the wrong state must leave the state unchanged, and a cold reset during sleep must bring the clock back.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;
  localparam int NUM_SECT = 4;
  localparam int PD_W     = NUM_SECT + 1;
  localparam int LINK_BIT = NUM_SECT;

  typedef enum logic [1:0] {
    SECT_ADC = 2'd0,
    SECT_DAC = 2'd1,
    SECT_MIX = 2'd2,
    SECT_REF = 2'd3
  } sect_e;

  // link-off request is honoured only when every section is off in the same word
  function automatic logic link_req_ok(input logic [PD_W-1:0] w);
    return w[LINK_BIT] && (&w[NUM_SECT-1:0]);
  endfunction

  // a sync pulse is a valid wake when its measured width reaches the minimum
  function automatic logic sync_wide_enough(input int unsigned width, input int unsigned min_w);
    return width >= min_w;
  endfunction
endpackage

// File: rtl/bitclk_gen.sv
module bitclk_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic bitclk
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] div_cnt;
  logic             bclk_q;
  logic             phase_end;

  assign phase_end = (div_cnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (halt) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (phase_end) begin
      div_cnt <= '0;
      bclk_q  <= ~bclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign bitclk = bclk_q;

  // halted link keeps the bit clock low
  assert_halt_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !bitclk);
endmodule

// File: rtl/sync_wake_det.sv
module sync_wake_det #(
  parameter int MIN_SYNC_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halted,
  input  logic sync_in,
  output logic wake
);
  import link_pwr_pkg::*;
  localparam int CNT_W = $clog2(MIN_SYNC_CYC + 1);

  logic             sync_s1, sync_s2, sync_s3;
  logic [CNT_W-1:0] width_cnt;
  logic             sync_fall;
  logic             width_ok;
  logic             wake_q;

  assign sync_fall = sync_s3 && !sync_s2;
  assign width_ok  = sync_wide_enough(int'(width_cnt), MIN_SYNC_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_s1 <= 1'b0;
      sync_s2 <= 1'b0;
      sync_s3 <= 1'b0;
    end else begin
      sync_s1 <= sync_in;
      sync_s2 <= sync_s1;
      sync_s3 <= sync_s2;
    end
  end

  // pulse width measured in crystal cycles, saturating at the threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_cnt <= '0;
    end else if (!halted || !sync_s2) begin
      width_cnt <= '0;
    end else if (!width_ok) begin
      width_cnt <= width_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= halted && sync_fall && width_ok;
  end

  assign wake = wake_q;

  assert_wake_needs_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> halted);
  assert_wake_needs_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(width_ok) && $past(sync_fall));
  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
endmodule

// File: rtl/pd_reg_ctrl.sv
module pd_reg_ctrl
  import link_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [PD_W-1:0] wdata,
  input  logic            frame_done,
  input  logic            wake,
  output logic [NUM_SECT-1:0] sect_q,
  output logic            link_pend,
  output logic            link_off
);
  logic pend_nxt;
  logic halt_now;

  assign pend_nxt = wr ? link_req_ok(wdata) : link_pend;
  assign halt_now = frame_done && pend_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q    <= '0;
      link_pend <= 1'b0;
      link_off  <= 1'b0;
    end else if (link_off) begin
      if (wake) link_off <= 1'b0;
    end else begin
      if (wr) sect_q <= wdata[NUM_SECT-1:0];
      link_pend <= halt_now ? 1'b0 : pend_nxt;
      if (halt_now) link_off <= 1'b1;
    end
  end

  assert_halt_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_off) |-> (&sect_q));
  assert_halt_at_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_off) |-> $past(frame_done));
  assert_sleep_static_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_off && !wake) |=> link_off && $stable(sect_q));
  assert_wake_keeps_sect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_off && wake) |=> !link_off && $stable(sect_q));
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
  import link_pwr_pkg::*;
#(
  parameter int CLK_DIV      = 2,
  parameter int MIN_SYNC_CYC = 25
) (
  input  logic            xtal_clk,
  input  logic            resetb,
  input  logic            sync_in,
  input  logic            pd_wr,
  input  logic [PD_W-1:0] pd_wdata,
  input  logic            frame_done,
  output logic            bitclk,
  output logic [NUM_SECT-1:0] sect_off,
  output logic            link_off,
  output logic [PD_W-1:0] pd_rdata,
  output logic [PD_W-1:0] ready
);
  logic [NUM_SECT-1:0] sect_q;
  logic                link_pend;
  logic                link_off_q;
  logic                wake_evt;

  pd_reg_ctrl u_regs (
    .clk        (xtal_clk),
    .rst_n      (resetb),
    .wr         (pd_wr),
    .wdata      (pd_wdata),
    .frame_done (frame_done),
    .wake       (wake_evt),
    .sect_q     (sect_q),
    .link_pend  (link_pend),
    .link_off   (link_off_q)
  );

  sync_wake_det #(.MIN_SYNC_CYC(MIN_SYNC_CYC)) u_wake (
    .clk     (xtal_clk),
    .rst_n   (resetb),
    .halted  (link_off_q),
    .sync_in (sync_in),
    .wake    (wake_evt)
  );

  bitclk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk    (xtal_clk),
    .rst_n  (resetb),
    .halt   (link_off_q),
    .bitclk (bitclk)
  );

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    assign sect_off[i] = sect_q[i];
    assign ready[i]    = ~sect_q[i];
    assign pd_rdata[i] = sect_q[i];
  end

  assign link_off           = link_off_q;
  assign ready[LINK_BIT]    = ~link_off_q;
  assign pd_rdata[LINK_BIT] = link_pend | link_off_q;

  assert_pend_or_off_R4: assert property (@(posedge xtal_clk) disable iff (!resetb)
    !(link_pend && link_off_q));
endmodule

// File: tb/sim_link_pwr_ctrl.sv
module sim_link_pwr_ctrl;
  logic       clk = 1'b0;
  logic       resetb = 1'b0;
  logic       sync_in = 1'b0;
  logic       pd_wr = 1'b0;
  logic [4:0] pd_wdata = '0;
  logic       frame_done = 1'b0;
  logic       bitclk;
  logic [3:0] sect_off;
  logic       link_off;
  logic [4:0] pd_rdata;
  logic [4:0] ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [4:0] rd;
    logic [3:0] so;
    logic       lo;
    int         edges;
  } exp_t;

  exp_t sb_q[$];
  bit   mon_busy = 1'b0;

  always #2.5 clk = ~clk;

  link_pwr_ctrl u0 (
    .xtal_clk(clk), .resetb(resetb), .sync_in(sync_in), .pd_wr(pd_wr),
    .pd_wdata(pd_wdata), .frame_done(frame_done), .bitclk(bitclk),
    .sect_off(sect_off), .link_off(link_off), .pd_rdata(pd_rdata), .ready(ready)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items, compares state then counts bit clock edges
  initial begin
    forever begin
      exp_t e;
      int   edges;
      logic prev;
      wait (sb_q.size() > 0);
      mon_busy = 1'b1;
      e = sb_q.pop_front();
      @(negedge clk);
      chk({e.tag, " rdata"}, int'(pd_rdata), int'(e.rd));
      chk({e.tag, " sect_off"}, int'(sect_off), int'(e.so));
      chk({e.tag, " link_off"}, int'(link_off), int'(e.lo));
      chk({e.tag, " ready"}, int'(ready), int'({~e.lo, ~e.so}));
      edges = 0;
      prev  = bitclk;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (bitclk && !prev) edges++;
        prev = bitclk;
      end
      chk({e.tag, " bitclk edges"}, edges, e.edges);
      mon_busy = 1'b0;
    end
  end

  task automatic expect_state(string tag, logic [4:0] rd, logic [3:0] so, logic lo);
    exp_t e;
    e.tag = tag; e.rd = rd; e.so = so; e.lo = lo; e.edges = lo ? 0 : 10;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    #1;
    wait (!mon_busy);
  endtask

  task automatic wr_pd(logic [4:0] d);
    @(negedge clk); pd_wr = 1'b1; pd_wdata = d;
    @(negedge clk); pd_wr = 1'b0; pd_wdata = '0;
  endtask

  task automatic frame_end();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic sync_pulse(int n);
    @(negedge clk); sync_in = 1'b1;
    repeat (n) @(negedge clk);
    sync_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    resetb = 1'b1;
    repeat (2) @(negedge clk);
    expect_state("R1 reset", 5'h00, 4'h0, 1'b0);

    wr_pd(5'h01); expect_state("R2 adc off", 5'h01, 4'h1, 1'b0);
    wr_pd(5'h03); expect_state("R2 dac off", 5'h03, 4'h3, 1'b0);
    wr_pd(5'h0F); expect_state("R2 all off", 5'h0F, 4'hF, 1'b0);

    wr_pd(5'h17); frame_end();
    expect_state("R3 partial request", 5'h07, 4'h7, 1'b0);

    wr_pd(5'h1F);
    expect_state("R4 pending", 5'h1F, 4'hF, 1'b0);
    frame_end();
    expect_state("R4 halted R5 clock low", 5'h1F, 4'hF, 1'b1);

    wr_pd(5'h00); frame_end();
    expect_state("R6 ignored while halted", 5'h1F, 4'hF, 1'b1);

    sync_pulse(24);
    expect_state("R8 short sync", 5'h1F, 4'hF, 1'b1);

    sync_pulse(25);
    expect_state("R7 wake", 5'h0F, 4'hF, 1'b0);

    sync_pulse(30);
    expect_state("R9 sync while running", 5'h0F, 4'hF, 1'b0);

    wr_pd(5'h1F); wr_pd(5'h0F); frame_end();
    expect_state("R11 cancel", 5'h0F, 4'hF, 1'b0);

    wr_pd(5'h1F); frame_end();
    expect_state("R10 halted again", 5'h1F, 4'hF, 1'b1);
    @(negedge clk); resetb = 1'b0;
    repeat (3) @(negedge clk); resetb = 1'b1;
    repeat (2) @(negedge clk);
    expect_state("R10 cold reset wake", 5'h00, 4'h0, 1'b0);

    finish_run();
  end
endmodule